// File: doc/BRIEF.md
# PLL Lock Sequencing Counter

This block decides when a phase-locked loop may be treated as settled. It runs entirely on the slow clock. When the PLL is enabled it loads a programmed settling count into a down-counter. When that counter has run out and the main oscillator reports stable, it raises a lock flag. Until then it keeps the PLL output bypassed, so the reference clock is routed around the PLL. The analog loop, its filter and the oscillator are modelled only as an enable input and a stable input.

Software programs the settling count and the multiplier through a single write strobe. The stored multiplier is driven out to the analog PLL. A write that changes the multiplier while the PLL is enabled drops the lock and restarts the whole settling sequence. The lock event sets a level interrupt flag. An enable gates that flag onto the interrupt output, and a status-read strobe clears it.

The sequencer has four states:
- ST_OFF: the PLL is disabled.
- ST_COUNT: the down-counter is running.
- ST_OSC_WAIT: the count has finished, or lock was lost, and the oscillator is not yet stable.
- ST_LOCKED: the PLL is locked.

Its transitions are:
- OFF→COUNT on enable.
- COUNT→COUNT while the counter is non-zero.
- COUNT→LOCKED, or COUNT→OSC_WAIT, when the counter is zero, depending on the oscillator.
- OSC_WAIT→LOCKED when the oscillator becomes stable.
- LOCKED→OSC_WAIT when the oscillator drops.
- COUNT, OSC_WAIT or LOCKED→COUNT on a multiplier change, which reloads the counter.
- any state→OFF when the PLL is disabled.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset, `lock` is 0, `bypass` is 1, `irq` is 0 and `pll_mul` is 0.
- R2: A sequence starts at the first slow-clock edge that samples `pll_en` high while in ST_OFF. With a programmed count N≥1 and `osc_stable` held high, `lock` rises at the (N+1)-th edge after that start edge and not before.
- R3: A programmed count of 0 behaves as a count of 1. `lock` can therefore never rise earlier than the 2nd edge after a start or restart edge.
- R4: If the counter finishes while `osc_stable` is low, `lock` stays 0. It rises at the first edge that samples `osc_stable` high.
- R5: If `osc_stable` is sampled low while locked, `lock` falls at that edge. `lock` returns at the first later edge that samples `osc_stable` high, with no recount.
- R6: Suppose `pll_en` is high and a write carries a multiplier different from `pll_mul`. Then `lock` is 0 after that edge, and the sequence restarts with the count supplied in that same write. `lock` rises at the (N+1)-th edge after the write edge.
- R7: Some writes leave `lock` unchanged: a write whose multiplier equals the stored one, and any write while `pll_en` is low. In every case `pll_mul` takes the written multiplier at the write edge.
- R8: An edge that samples `pll_en` low leaves `lock` at 0 and clears the sequence.
- R9: `bypass` is always the inverse of `lock`.
- R10: The interrupt flag sets at the edge where `lock` rises. `irq` is the flag ANDed with `irq_en`. An edge sampling `stat_rd` high clears the flag, except that a set at the same edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock; all state runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for count and multiplier |
| cfg_count | input | CNT_W | Settling count to store (0 is treated as 1) |
| cfg_mul | input | MUL_W | Multiplier to store |
| pll_en | input | 1 | PLL enable |
| osc_stable | input | 1 | Main oscillator reports stable |
| irq_en | input | 1 | Interrupt enable mask |
| stat_rd | input | 1 | Status read strobe; clears the interrupt flag |
| lock | output | 1 | PLL locked status |
| irq | output | 1 | Masked lock interrupt request |
| bypass | output | 1 | High while the reference clock is routed around the PLL |
| pll_mul | output | MUL_W | Stored multiplier driven to the PLL |

## Verification
An error in the down-counter or in the state register shows at `lock` as a rise on the wrong edge. For the count-to-lock path, that is the edge where the correct design would first raise `lock`: at most N+1 edges after the start edge. The bench therefore records the exact edge at which `lock` first rises, for every count value of a narrow configuration. A lost multiplier-change compare or a misplaced oscillator gate shows within one edge, as `lock` staying high or rising while the oscillator is low. A wrong interrupt flag shows on `irq` at the lock edge, or at the edge after a read.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_COUNT    = 2'd1,
        ST_OSC_WAIT = 2'd2,
        ST_LOCKED   = 2'd3
    } lock_state_e;

endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs #(
    parameter int CNT_W = 8,
    parameter int MUL_W = 11
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [MUL_W-1:0] cfg_mul,
    output logic [CNT_W-1:0] load_count,
    output logic [MUL_W-1:0] mul_q,
    output logic             mul_change
);

    localparam logic [CNT_W-1:0] MIN_COUNT = CNT_W'(1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] wr_count_eff;

    // a zero count is raised to the minimum
    always_comb begin
        wr_count_eff = (cfg_count == '0) ? MIN_COUNT : cfg_count;
        load_count   = cfg_wr ? wr_count_eff : count_q;
        mul_change   = cfg_wr && (cfg_mul != mul_q);
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= MIN_COUNT;
            mul_q   <= '0;
        end else if (cfg_wr) begin
            count_q <= wr_count_eff;
            mul_q   <= cfg_mul;
        end
    end

endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_lock_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             pll_en,
    input  logic             osc_stable,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_count,
    output logic             lock,
    output logic             lock_set
);

    lock_state_e      state_q, state_d;
    logic [CNT_W-1:0] dcnt_q, dcnt_d;
    logic             cnt_zero;

    assign cnt_zero = (dcnt_q == '0);

    // next state and counter
    always_comb begin
        state_d = state_q;
        dcnt_d  = dcnt_q;
        if (!pll_en) begin
            state_d = ST_OFF;
            dcnt_d  = '0;
        end else if (restart && state_q != ST_OFF) begin
            state_d = ST_COUNT;
            dcnt_d  = load_count;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_COUNT;
                    dcnt_d  = load_count;
                end
                ST_COUNT: begin
                    if (cnt_zero) begin
                        state_d = osc_stable ? ST_LOCKED : ST_OSC_WAIT;
                    end else begin
                        dcnt_d = dcnt_q - CNT_W'(1);
                    end
                end
                ST_OSC_WAIT: begin
                    if (osc_stable) state_d = ST_LOCKED;
                end
                ST_LOCKED: begin
                    if (!osc_stable) state_d = ST_OSC_WAIT;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            dcnt_q  <= dcnt_d;
        end
    end

    // outputs
    always_comb begin
        lock     = (state_q == ST_LOCKED);
        lock_set = (state_d == ST_LOCKED) && (state_q != ST_LOCKED);
    end

endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq (
    input  logic clk_slow,
    input  logic rst_n,
    input  logic lock_set,
    input  logic stat_rd,
    input  logic irq_en,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (lock_set) flag_q <= 1'b1;
        else if (stat_rd)  flag_q <= 1'b0;
    end

    assign irq = flag_q & irq_en;

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq #(
    parameter int CNT_W = 8,
    parameter int MUL_W = 11
) (
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [MUL_W-1:0] cfg_mul,
    input  logic             pll_en,
    input  logic             osc_stable,
    input  logic             irq_en,
    input  logic             stat_rd,
    output logic             lock,
    output logic             irq,
    output logic             bypass,
    output logic [MUL_W-1:0] pll_mul
);

    logic [CNT_W-1:0] load_count;
    logic             mul_change;
    logic             lock_set;

    pll_cfg_regs #(.CNT_W(CNT_W), .MUL_W(MUL_W)) u_cfg (
        .clk_slow   (clk_slow),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_count  (cfg_count),
        .cfg_mul    (cfg_mul),
        .load_count (load_count),
        .mul_q      (pll_mul),
        .mul_change (mul_change)
    );

    pll_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_slow   (clk_slow),
        .rst_n      (rst_n),
        .pll_en     (pll_en),
        .osc_stable (osc_stable),
        .restart    (mul_change),
        .load_count (load_count),
        .lock       (lock),
        .lock_set   (lock_set)
    );

    pll_lock_irq u_irq (
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .lock_set (lock_set),
        .stat_rd  (stat_rd),
        .irq_en   (irq_en),
        .irq      (irq)
    );

    assign bypass = ~lock;

endmodule

// File: rtl/pll_lock_chk.sv
module pll_lock_chk #(
    parameter int MUL_W = 11
) (
    input logic             clk_slow,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [MUL_W-1:0] cfg_mul,
    input logic             pll_en,
    input logic             osc_stable,
    input logic             irq_en,
    input logic             stat_rd,
    input logic             lock,
    input logic             irq,
    input logic             bypass,
    input logic [MUL_W-1:0] pll_mul
);

    p_disable_clears_r8: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !pll_en |=> (!lock && bypass));

    p_osc_gate_r4: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(lock) |-> $past(osc_stable));

    p_min_delay_r3: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(lock) |-> ($past(pll_en) && $past(pll_en, 2)));

    p_mul_restart_r6: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (pll_en && cfg_wr && (cfg_mul != pll_mul)) |=> !lock);

    p_same_mul_r7: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (pll_en && lock && osc_stable && !(cfg_wr && (cfg_mul != pll_mul))) |=> lock);

    p_irq_on_lock_r10: assert property (@(posedge clk_slow) disable iff (!rst_n)
        ($rose(lock) && irq_en) |-> irq);

    p_irq_clear_r10: assert property (@(posedge clk_slow) disable iff (!rst_n)
        (stat_rd && lock) |=> !irq);

endmodule

bind pll_lock_seq pll_lock_chk #(.MUL_W(MUL_W)) i_chk (
    .clk_slow   (clk_slow),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_mul    (cfg_mul),
    .pll_en     (pll_en),
    .osc_stable (osc_stable),
    .irq_en     (irq_en),
    .stat_rd    (stat_rd),
    .lock       (lock),
    .irq        (irq),
    .bypass     (bypass),
    .pll_mul    (pll_mul)
);

// File: tb/test_pll_lock_seq.sv
module test_pll_lock_seq;

    localparam int CNT_W = 4;
    localparam int MUL_W = 6;

    logic             clk_slow = 1'b0;
    logic             rst_n;
    logic             cfg_wr;
    logic [CNT_W-1:0] cfg_count;
    logic [MUL_W-1:0] cfg_mul;
    logic             pll_en, osc_stable, irq_en, stat_rd;
    logic             lock, irq, bypass;
    logic [MUL_W-1:0] pll_mul;

    int checks = 0;
    int failures = 0;

    always #2.5 clk_slow = ~clk_slow;

    pll_lock_seq #(.CNT_W(CNT_W), .MUL_W(MUL_W)) i_pll_lock_seq (
        .clk_slow(clk_slow), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
        .cfg_mul(cfg_mul), .pll_en(pll_en), .osc_stable(osc_stable), .irq_en(irq_en),
        .stat_rd(stat_rd), .lock(lock), .irq(irq), .bypass(bypass), .pll_mul(pll_mul)
    );

    task automatic tick();
        @(posedge clk_slow);
        @(negedge clk_slow);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int cnt, int mul);
        cfg_wr = 1'b1; cfg_count = CNT_W'(cnt); cfg_mul = MUL_W'(mul);
        tick();
        cfg_wr = 1'b0;
    endtask

    // returns tick index (1 = start edge) at which lock first is seen high
    task automatic wait_lock(output int first);
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            tick();
            if (lock && first == 0) first = k;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_slow);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int first;
        rst_n = 1'b0; cfg_wr = 0; cfg_count = 0; cfg_mul = 0;
        pll_en = 0; osc_stable = 0; irq_en = 0; stat_rd = 0;
        repeat (3) tick();
        check("R1 lock", int'(lock), 0);
        check("R1 bypass", int'(bypass), 1);
        check("R1 irq", int'(irq), 0);
        check("R1 pll_mul", int'(pll_mul), 0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R9 R10: sweep every count value
        irq_en = 1'b1;
        for (int n = 0; n < (1 << CNT_W); n++) begin
            int exp_edges;
            pll_en = 0; osc_stable = 1;
            tick();
            wr(n, n + 1);                         // R7 write while disabled
            check("R7 mul while off", int'(pll_mul), n + 1);
            check("R8 lock off", int'(lock), 0);
            pll_en = 1;
            wait_lock(first);
            exp_edges = ((n == 0) ? 1 : n) + 1;
            check(n == 0 ? "R3 zero count delay" : "R2 lock delay", first - 1, exp_edges);
            check("R9 bypass", int'(bypass), int'(!lock));
            check("R10 irq at lock", int'(irq), 1);
            stat_rd = 1; tick(); stat_rd = 0;
            check("R10 irq cleared", int'(irq), 0);
        end

        // R8 disable
        pll_en = 0; tick();
        check("R8 lock cleared", int'(lock), 0);
        check("R9 bypass high", int'(bypass), 1);

        // R4 oscillator gates lock
        wr(3, 5);
        osc_stable = 0; pll_en = 1;
        repeat (10) tick();
        check("R4 no lock without osc", int'(lock), 0);
        osc_stable = 1; tick();
        check("R4 lock on osc", int'(lock), 1);

        // R5 osc drop and return without recount
        osc_stable = 0; tick();
        check("R5 lock lost", int'(lock), 0);
        osc_stable = 1; tick();
        check("R5 relock immediate", int'(lock), 1);

        // R7 same multiplier while locked
        wr(9, 5);
        check("R7 same mul lock kept", int'(lock), 1);

        // R6 new multiplier restarts with new count
        cfg_wr = 1; cfg_count = 4; cfg_mul = 7;
        tick();
        cfg_wr = 0;
        check("R6 lock dropped", int'(lock), 0);
        check("R6 pll_mul", int'(pll_mul), 7);
        first = 0;
        for (int k = 2; k <= 20; k++) begin
            tick();
            if (lock && first == 0) first = k;
        end
        check("R6 restart delay", first - 1, 5);

        // R10 mask and set-over-clear
        stat_rd = 1; tick(); stat_rd = 0;
        irq_en = 0;
        pll_en = 0; tick(); pll_en = 1;
        wr(1, 7);
        tick();
        stat_rd = 1; tick(); stat_rd = 0;     // lock rises on this edge, set wins
        check("R10 lock up", int'(lock), 1);
        check("R10 masked irq", int'(irq), 0);
        irq_en = 1; #1;
        check("R10 flag survived read", int'(irq), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule